// File: doc/BRIEF.md
# Dual-Clock FIFO with Five Status Flags

This block is an 18-bit first-in first-out buffer. The write port and the read port each have their own free-running clock, so the two clocks can be tied together or run independently. A word is stored on every rising write-clock edge while the active-low write enable is held low. A word is fetched on every rising read-clock edge while the active-low read enable is held low. A separate active-low output enable gates the data output and raises a valid qualifier. The pointers are Gray-coded and cross into the opposite domain through two-flop synchronizers.

Five status outputs report the fill level: empty, almost empty, half full, almost full and full. Empty is owned by the read clock and full by the write clock. The almost-empty and almost-full offsets are loaded through a small register-write port. A mode input chooses the almost-flag style. Held low, the almost flags are registered on their own domain's clock. Held high, they follow the true word count with no clock at all. A retransmit input rewinds the read pointer to the first stored address, so the data can be replayed.

Top module: `dcfifo_flags`

## Requirements
- R1: While and after reset, empty=1, almost_empty=1, half_full=0, almost_full=0, full=0, and both almost offsets return to 7.
- R2: Words leave in the order they were written. The word fetched at a read-clock edge where rd_en_n=0 and empty=0 appears on rd_data after that edge.
- R3: A write while full and a read while empty are ignored. The stored words, the pointers and rd_data stay unchanged.
- R4: empty=1 exactly when the read side sees zero stored words. It is driven only by read-clock logic, and with tied clocks it clears by the third edge after a write.
- R5: full=1 exactly when the write side sees DEPTH stored words, and it is driven only by write-clock logic.
- R6: With count the settled number of stored words: almost_empty=1 when count is at most the almost-empty offset, almost_full=1 when count is at least DEPTH minus the almost-full offset, and half_full=1 when count is at least DEPTH/2.
- R7: A write-clock edge with cfg_we=1 loads cfg_data into the almost-empty offset when cfg_sel=0, and into the almost-full offset when cfg_sel=1.
- R8: With sync_mode_n=0 the almost flags are registered on their own clock. With tied clocks, a write changes almost_empty on the fourth edge. With sync_mode_n=1 they follow the true count right after the edge that changes it.
- R9: A read-clock edge with retx=1 sets the read pointer to address zero. The stored data and the write pointer are kept, so the count becomes the number of words written since reset.
- R10: rd_oe_n=1 forces rd_data to zero and rd_valid to 0. rd_oe_n=0 presents the last fetched word with rd_valid=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Write clock |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | 18 | Write data |
| cfg_we | input | 1 | Offset register write strobe (write clock) |
| cfg_sel | input | 1 | 0 selects almost-empty offset, 1 selects almost-full offset |
| cfg_data | input | 6 | Offset value in words |
| sync_mode_n | input | 1 | 0 = registered almost flags, 1 = unclocked almost flags |
| rd_clk | input | 1 | Read clock |
| rd_en_n | input | 1 | Active-low read enable |
| rd_oe_n | input | 1 | Active-low output enable |
| retx | input | 1 | Retransmit: rewind read pointer to zero |
| rd_data | output | 18 | Read data, zero when output is disabled |
| rd_valid | output | 1 | High while the output is enabled |
| empty | output | 1 | No words visible to the read side |
| almost_empty | output | 1 | Fill level at or below the almost-empty offset |
| half_full | output | 1 | Fill level at least half of DEPTH |
| almost_full | output | 1 | Fill level at or above DEPTH minus almost-full offset |
| full | output | 1 | DEPTH words visible to the write side |

## Verification
The assertions assume three things. Empty can only rise after a read-enable cycle or a retransmit. Full and half full can only rise after a write-enable cycle. The flags therefore never move because of the synchronized pointer alone. They also assume that offsets change only while the buffer is quiet, because the almost-empty offset is sampled in the read domain. The stimulus ties both clocks together, writes offsets only between bursts, and pulses retransmit with the read enable off. It issues retransmit only before the writer has wrapped past DEPTH words, so the rewound count stays valid.

// File: rtl/dcfifo_flags.sv
module dcfifo_flags #(
  parameter int DEPTH  = 64,
  parameter int WIDTH  = 18,
  parameter int AE_DEF = 7,
  parameter int AF_DEF = 7
) (
  input  logic                     rst_n,
  input  logic                     wr_clk,
  input  logic                     wr_en_n,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic                     cfg_we,
  input  logic                     cfg_sel,
  input  logic [$clog2(DEPTH)-1:0] cfg_data,
  input  logic                     sync_mode_n,
  input  logic                     rd_clk,
  input  logic                     rd_en_n,
  input  logic                     rd_oe_n,
  input  logic                     retx,
  output logic [WIDTH-1:0]         rd_data,
  output logic                     rd_valid,
  output logic                     empty,
  output logic                     almost_empty,
  output logic                     half_full,
  output logic                     almost_full,
  output logic                     full
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] HALF  = PW'(DEPTH / 2);
  localparam logic [PW-1:0] FULLV = PW'(DEPTH);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, wq1, wq2, wbin_n;
  logic [PW-1:0] rbin, rgray, rq1, rq2, rbin_n;
  logic [PW-1:0] wr_cnt, rd_cnt, raw_cnt, af_thr;
  logic [AW-1:0] ae_off, af_off;
  logic [WIDTH-1:0] rd_q;
  logic ae_q, af_q, push, pop;

  assign wbin_n  = wbin + 1'b1;
  assign rbin_n  = rbin + 1'b1;
  assign full    = (wgray == {~wq2[PW-1:PW-2], wq2[PW-3:0]});
  assign empty   = (rgray == rq2);
  assign push    = !wr_en_n && !full;
  assign pop     = !rd_en_n && !empty;

  assign wr_cnt  = wbin - g2b(wq2);
  assign rd_cnt  = g2b(rq2) - rbin;
  assign raw_cnt = wbin - rbin;
  assign af_thr  = FULLV - {1'b0, af_off};

  // write domain
  always_ff @(posedge wr_clk)
    if (push) mem[wbin[AW-1:0]] <= wr_data;

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      wq1    <= '0;
      wq2    <= '0;
      af_q   <= 1'b0;
      ae_off <= AW'(AE_DEF);
      af_off <= AW'(AF_DEF);
    end else begin
      wq1  <= rgray;
      wq2  <= wq1;
      af_q <= (wr_cnt >= af_thr);
      if (push) begin
        wbin  <= wbin_n;
        wgray <= wbin_n ^ (wbin_n >> 1);
      end
      if (cfg_we) begin
        if (cfg_sel) af_off <= cfg_data;
        else         ae_off <= cfg_data;
      end
    end

  assign half_full = (wr_cnt >= HALF);

  // read domain
  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      rq1   <= '0;
      rq2   <= '0;
      rd_q  <= '0;
      ae_q  <= 1'b1;
    end else begin
      rq1  <= wgray;
      rq2  <= rq1;
      ae_q <= (rd_cnt <= {1'b0, ae_off});
      if (retx) begin
        rbin  <= '0;
        rgray <= '0;
      end else if (pop) begin
        rd_q  <= mem[rbin[AW-1:0]];
        rbin  <= rbin_n;
        rgray <= rbin_n ^ (rbin_n >> 1);
      end
    end

  assign almost_empty = sync_mode_n ? (raw_cnt <= {1'b0, ae_off}) : ae_q;
  assign almost_full  = sync_mode_n ? (raw_cnt >= af_thr) : af_q;

  assign rd_valid = !rd_oe_n;
  assign rd_data  = rd_oe_n ? '0 : rd_q;
endmodule

// File: rtl/dcfifo_flags_chk.sv
module dcfifo_flags_chk #(
  parameter int PW    = 7,
  parameter int WIDTH = 18
) (
  input logic             rst_n,
  input logic             wr_clk,
  input logic             rd_clk,
  input logic             wr_en_n,
  input logic             rd_en_n,
  input logic             retx,
  input logic             empty,
  input logic             full,
  input logic             half_full,
  input logic [PW-1:0]    wbin,
  input logic [PW-1:0]    rbin,
  input logic [WIDTH-1:0] rd_q
);
  a_r3_no_push_when_full: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (full && !wr_en_n) |=> $stable(wbin));

  a_r3_no_pop_when_empty: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (empty && !rd_en_n && !retx) |=> ($stable(rbin) && $stable(rd_q)));

  a_r4_empty_rises_after_read: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $rose(empty) |-> ($past(!rd_en_n) || $past(retx)));

  a_r5_full_rises_after_write: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $rose(full) |-> $past(!wr_en_n));

  a_r6_half_rises_after_write: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $rose(half_full) |-> $past(!wr_en_n));
endmodule

bind dcfifo_flags dcfifo_flags_chk #(.PW(PW), .WIDTH(WIDTH)) u_chk (
  .rst_n(rst_n), .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_en_n(wr_en_n),
  .rd_en_n(rd_en_n), .retx(retx), .empty(empty), .full(full),
  .half_full(half_full), .wbin(wbin), .rbin(rbin), .rd_q(rd_q)
);

// File: tb/dcfifo_flags_tb.sv
module dcfifo_flags_tb;
  localparam int DEPTH = 64;
  localparam int W     = 18;
  localparam int NOPS  = 10;
  // {op, count}: op 0 = write, 1 = read, 2 = write and read together
  localparam logic [9:0] OPS [NOPS] = '{
    {2'd0, 8'd5},  {2'd0, 8'd10}, {2'd2, 8'd20}, {2'd1, 8'd15}, {2'd0, 8'd32},
    {2'd0, 8'd25}, {2'd0, 8'd10}, {2'd1, 8'd64}, {2'd1, 8'd3},  {2'd0, 8'd8}
  };

  logic clk = 1'b0;
  logic rst_n, wr_en_n, rd_en_n, rd_oe_n, retx, cfg_we, cfg_sel, sync_mode_n;
  logic [W-1:0] wr_data, rd_data, last_rd;
  logic [5:0] cfg_data;
  logic rd_valid, empty, almost_empty, half_full, almost_full, full;

  logic [W-1:0] hist [DEPTH];
  int wi, ri, ae_off, af_off, checks, fails;

  always #2 clk = ~clk;

  dcfifo_flags u_dut (
    .rst_n(rst_n), .wr_clk(clk), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .sync_mode_n(sync_mode_n), .rd_clk(clk), .rd_en_n(rd_en_n),
    .rd_oe_n(rd_oe_n), .retx(retx), .rd_data(rd_data), .rd_valid(rd_valid),
    .empty(empty), .almost_empty(almost_empty), .half_full(half_full),
    .almost_full(almost_full), .full(full)
  );

  function automatic logic [W-1:0] pat(int i);
    return W'(i * 499 + 7) ^ 18'h15A5A;
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag);
    int c;
    logic [4:0] e, a;
    c = wi - ri;
    e = {c == 0, c <= ae_off, c >= DEPTH / 2, c >= DEPTH - af_off, c == DEPTH};
    a = {empty, almost_empty, half_full, almost_full, full};
    check(a == e, tag, int'(a), int'(e));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wi = 0; ri = 0; ae_off = 7; af_off = 7;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic w, input logic r);
    logic wa, ra;
    logic [W-1:0] exp;
    wa = w && (wi - ri) < DEPTH;
    ra = r && (wi - ri) > 0;
    exp = hist[ri % DEPTH];
    wr_en_n = !w;
    rd_en_n = !r;
    wr_data = pat(wi);
    @(posedge clk);
    if (ra) ri++;
    if (wa) begin
      hist[wi % DEPTH] = pat(wi);
      wi++;
    end
    @(negedge clk);
    wr_en_n = 1'b1;
    rd_en_n = 1'b1;
    if (ra) begin
      check(rd_data == exp, "R2 read order", int'(rd_data), int'(exp));
      last_rd = rd_data;
    end else if (r) begin
      check(rd_data == last_rd, "R3 read while empty ignored", int'(rd_data), int'(last_rd));
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic sel, input logic [5:0] v);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0; last_rd = '0;
    rst_n = 1'b0; wr_en_n = 1'b1; rd_en_n = 1'b1; rd_oe_n = 1'b0; retx = 1'b0;
    cfg_we = 1'b0; cfg_sel = 1'b0; cfg_data = '0; sync_mode_n = 1'b0; wr_data = '0;
    do_reset();
    chk_flags("R1 reset flags");
    check(rd_data == '0, "R1 reset data", int'(rd_data), 0);

    for (int k = 0; k < NOPS; k++) begin
      for (int n = 0; n < int'(OPS[k][7:0]); n++)
        step(OPS[k][9:8] != 2'd1, OPS[k][9:8] != 2'd0);
      idle(6);
      chk_flags($sformatf("R4 R5 R6 vector %0d", k));
    end

    // R7 offsets through the config port (count is 8 here)
    cfg(1'b0, 6'd3); cfg(1'b1, 6'd10);
    ae_off = 3; af_off = 10;
    idle(4);
    chk_flags("R7 new offsets at 8");
    for (int n = 0; n < 5; n++) step(1'b0, 1'b1);
    idle(6);
    chk_flags("R7 almost empty at 3");
    for (int n = 0; n < 50; n++) step(1'b1, 1'b0);
    idle(6);
    chk_flags("R7 almost full off at 53");
    step(1'b1, 1'b0);
    idle(6);
    chk_flags("R7 almost full on at 54");

    // R10 output enable
    rd_oe_n = 1'b1;
    #1;
    check(rd_data == '0 && !rd_valid, "R10 output disabled", int'({rd_valid, rd_data}), 0);
    rd_oe_n = 1'b0;
    #1;
    check(rd_data == last_rd && rd_valid, "R10 output enabled",
          int'({rd_valid, rd_data}), int'({1'b1, last_rd}));

    // R1 reset with data stored
    do_reset();
    last_rd = '0;
    chk_flags("R1 reset after fill");

    // R8 almost flag modes
    for (int n = 0; n < 7; n++) step(1'b1, 1'b0);
    idle(6);
    sync_mode_n = 1'b1;
    step(1'b1, 1'b0);
    check(almost_empty == 1'b0, "R8 unclocked ae clears at once", int'(almost_empty), 0);
    step(1'b0, 1'b1);
    check(almost_empty == 1'b1, "R8 unclocked ae sets at once", int'(almost_empty), 1);
    sync_mode_n = 1'b0;
    idle(6);
    check(almost_empty == 1'b1, "R8 registered ae at 7", int'(almost_empty), 1);
    step(1'b1, 1'b0);
    check(almost_empty == 1'b1, "R8 registered ae edge 1", int'(almost_empty), 1);
    idle(2);
    check(almost_empty == 1'b1, "R8 registered ae edge 3", int'(almost_empty), 1);
    idle(1);
    check(almost_empty == 1'b0, "R8 registered ae edge 4", int'(almost_empty), 0);

    // R9 retransmit
    do_reset();
    last_rd = '0;
    for (int n = 0; n < 10; n++) step(1'b1, 1'b0);
    idle(6);
    for (int n = 0; n < 4; n++) step(1'b0, 1'b1);
    retx = 1'b1;
    @(negedge clk);
    retx = 1'b0;
    ri = 0;
    idle(6);
    chk_flags("R9 count after retransmit");
    for (int n = 0; n < 10; n++) step(1'b0, 1'b1);
    idle(6);
    chk_flags("R9 R4 empty after replay");

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule